// File: doc/BRIEF.md
# Encoded-Ratio Programmable Clock Divider

This block derives one divided clock from a choice of reference clocks. The references arrive as single-cycle enables in one clock domain. Two control words are written through a small write port. One field picks the reference. A second field holds an encoded division ratio, and each instance decodes it by its own rule. The decoded ratio is the field value plus one, times a step. When a special value is configured for code zero, code zero yields that fixed ratio instead. An instance may also have no select field, in which case it always uses reference 0. An instance with no ratio field always divides by one.

The output is a pulse-rate enable (`div_en`, one pulse per divided period, on the last source tick of the period) and a level waveform (`div_clk`). A readback port shows the raw fields, the selected source index, whether that index names a real source, and the decoded ratio.

The divider is a four-state machine. `ST_STOP` is entered from reset and from any other state as soon as the select code is out of range. It leaves for `ST_PASS` or `ST_HIGH` once the code is valid. `ST_PASS` runs ratio 1 and reloads the ratio on every tick. `ST_HIGH` drives the level high and moves to `ST_LOW` after half the ratio in ticks. `ST_LOW` counts to the end of the period, where it reloads the ratio and returns to `ST_HIGH`, or goes to `ST_PASS` if the new ratio is 1.

Top module: `ratio_clk_div`

## Requirements
- R1: While reset is held, both control words are zero, `div_en` and `div_clk` are low, and the readback shows select code 0 as valid along with the ratio that code 0 of the ratio field decodes to.
- R2: A write with `wr_addr`=0 loads control word 0 and a write with `wr_addr`=1 loads word 1. The select field sits at bit `SEL_LSB` (8) of word 0. The ratio field sits at bit `RAT_LSB` of word `RAT_REG`, and bits outside it do not change the decoded ratio.
- R3: A nonzero ratio field F decodes to (F+1)*`RAT_STEP`, shown on `rd_ratio`; the decoded ratio is never zero.
- R4: When `RAT_ZERO` is nonzero, ratio field 0 decodes to `RAT_ZERO`.
- R5: Select code S with S < `NUM_SRC` makes `src_tick[S]` the tick stream. With S >= `NUM_SRC`, `rd_src_ok` is low and `div_en` and `div_clk` stay low.
- R6: An instance with no select field and no ratio field passes `src_tick[0]` through with ratio 1.
- R7: For ratio R, `div_en` pulses once every R source ticks, on a source tick, and the interval between pulses is R ticks.
- R8: For R >= 2, `div_clk` is high for floor(R/2) ticks starting right after a period boundary and low for the rest. For R = 1, `div_clk` equals the selected tick.
- R9: A new ratio takes effect only at the next period boundary; the period in progress completes with the old ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | NUM_SRC | One enable per reference source |
| wr_en | input | 1 | Control word write strobe |
| wr_addr | input | 1 | Selects control word 0 or 1 |
| wr_data | input | DATA_W | Write data |
| div_en | output | 1 | One pulse per divided period |
| div_clk | output | 1 | Divided level waveform |
| rd_src | output | max(SEL_W,1) | Selected source index |
| rd_src_ok | output | 1 | Selected index names a real source |
| rd_rat_raw | output | max(RAT_W,1) | Raw ratio field |
| rd_ratio | output | RATIO_W | Decoded ratio |

## Verification
The bench builds three instances.

The first uses the defaults: three sources, a two-bit select field, and a five-bit ratio field with step 2 and zero code 20 held in word 1 at bit 24. This instance reaches the zero-code ratio, even ratios up to 64, an out-of-range select code, and changes of source with ticks every one, two and three cycles.

The second instance has two sources, a one-bit select field, and a three-bit step-1 field at bit 0 of word 0. It covers odd ratios, ratio 1 pass-through, and a ratio field that shares its word with the select field.

The third instance has no fields at all and checks the fixed-source, divide-by-one case.

// File: rtl/rcd_pkg.sv
package rcd_pkg;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_PASS = 2'd1,
        ST_HIGH = 2'd2,
        ST_LOW  = 2'd3
    } rcd_state_e;

    // Largest ratio an instance can decode to.
    function automatic int max_ratio(int rat_w, int step, int zero_val);
        int m;
        m = (rat_w == 0) ? 1 : ((1 << rat_w) * step);
        if (zero_val > m) m = zero_val;
        return m;
    endfunction

endpackage

// File: rtl/rcd_regs.sv
module rcd_regs #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] word0,
    output logic [DATA_W-1:0] word1
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word0 <= '0;
            word1 <= '0;
        end else if (wr_en) begin
            if (wr_addr) word1 <= wr_data;
            else         word0 <= wr_data;
        end
    end

endmodule

// File: rtl/rcd_decode.sv
module rcd_decode #(
    parameter int DATA_W   = 32,
    parameter int NUM_SRC  = 3,
    parameter int SEL_W    = 2,
    parameter int SEL_LSB  = 8,
    parameter int RAT_W    = 5,
    parameter int RAT_LSB  = 24,
    parameter int RAT_REG  = 1,
    parameter int RAT_STEP = 2,
    parameter int RAT_ZERO = 20,
    parameter int RATIO_W  = 7,
    parameter int SW       = 2,
    parameter int RW       = 5
) (
    input  logic [DATA_W-1:0]  word0,
    input  logic [DATA_W-1:0]  word1,
    input  logic [NUM_SRC-1:0] src_tick,
    output logic [SW-1:0]      sel_code,
    output logic               sel_ok,
    output logic               sel_tick,
    output logic [RW-1:0]      rat_raw,
    output logic [RATIO_W-1:0] ratio
);

    logic unused_word_bits;
    assign unused_word_bits = ^{word0, word1};

    generate
        if (SEL_W > 0) begin : g_sel
            assign sel_code = word0[SEL_LSB +: SEL_W];
            assign sel_ok   = int'(sel_code) < NUM_SRC;
        end else begin : g_fixed_src
            assign sel_code = '0;
            assign sel_ok   = 1'b1;
        end
    endgenerate

    always_comb begin
        sel_tick = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (sel_ok && int'(sel_code) == i) sel_tick = src_tick[i];
        end
    end

    generate
        if (RAT_W > 0) begin : g_rat
            logic [DATA_W-1:0] rat_word;
            assign rat_word = (RAT_REG != 0) ? word1 : word0;
            assign rat_raw  = rat_word[RAT_LSB +: RAT_W];
            always_comb begin
                if (RAT_ZERO != 0 && rat_raw == '0)
                    ratio = RATIO_W'(RAT_ZERO);
                else
                    ratio = RATIO_W'((int'(rat_raw) + 1) * RAT_STEP);
            end
        end else begin : g_no_rat
            assign rat_raw = '0;
            assign ratio   = RATIO_W'(1);
        end
    endgenerate

endmodule

// File: rtl/rcd_fsm.sv
module rcd_fsm
    import rcd_pkg::*;
#(
    parameter int RATIO_W = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_ok,
    input  logic               sel_tick,
    input  logic [RATIO_W-1:0] new_ratio,
    output logic               div_en,
    output logic               div_clk,
    output rcd_state_e         st,
    output logic [RATIO_W-1:0] act_ratio
);

    localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

    rcd_state_e         st_n;
    logic [RATIO_W-1:0] cnt, cnt_n, r_n, half;
    logic               last_tick;

    assign half      = act_ratio >> 1;
    assign last_tick = (cnt == act_ratio - ONE);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_STOP;
            cnt       <= '0;
            act_ratio <= ONE;
        end else begin
            st        <= st_n;
            cnt       <= cnt_n;
            act_ratio <= r_n;
        end
    end

    // Next state
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        r_n   = act_ratio;
        unique case (st)
            ST_STOP: begin
                if (sel_ok) begin
                    r_n   = new_ratio;
                    cnt_n = '0;
                    st_n  = (new_ratio == ONE) ? ST_PASS : ST_HIGH;
                end
            end
            ST_PASS: begin
                if (!sel_ok) begin
                    st_n = ST_STOP;
                end else if (sel_tick) begin
                    r_n   = new_ratio;
                    cnt_n = '0;
                    st_n  = (new_ratio == ONE) ? ST_PASS : ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (!sel_ok) begin
                    st_n = ST_STOP;
                end else if (sel_tick) begin
                    cnt_n = cnt + ONE;
                    if (cnt + ONE == half) st_n = ST_LOW;
                end
            end
            ST_LOW: begin
                if (!sel_ok) begin
                    st_n = ST_STOP;
                end else if (sel_tick) begin
                    if (last_tick) begin
                        r_n   = new_ratio;
                        cnt_n = '0;
                        st_n  = (new_ratio == ONE) ? ST_PASS : ST_HIGH;
                    end else begin
                        cnt_n = cnt + ONE;
                    end
                end
            end
            default: st_n = ST_STOP;
        endcase
    end

    // Outputs
    always_comb begin
        div_en  = 1'b0;
        div_clk = 1'b0;
        if (sel_ok) begin
            unique case (st)
                ST_PASS: begin
                    div_en  = sel_tick;
                    div_clk = sel_tick;
                end
                ST_HIGH: div_clk = 1'b1;
                ST_LOW:  div_en  = sel_tick && last_tick;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ratio_clk_div.sv
module ratio_clk_div
    import rcd_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_SRC  = 3,
    parameter int SEL_W    = 2,
    parameter int SEL_LSB  = 8,
    parameter int RAT_W    = 5,
    parameter int RAT_LSB  = 24,
    parameter int RAT_REG  = 1,
    parameter int RAT_STEP = 2,
    parameter int RAT_ZERO = 20,
    localparam int MAXR    = max_ratio(RAT_W, RAT_STEP, RAT_ZERO),
    localparam int RATIO_W = $clog2(MAXR + 1),
    localparam int SW      = (SEL_W > 0) ? SEL_W : 1,
    localparam int RW      = (RAT_W > 0) ? RAT_W : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_tick,
    input  logic               wr_en,
    input  logic               wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               div_en,
    output logic               div_clk,
    output logic [SW-1:0]      rd_src,
    output logic               rd_src_ok,
    output logic [RW-1:0]      rd_rat_raw,
    output logic [RATIO_W-1:0] rd_ratio
);

    logic [DATA_W-1:0]  word0, word1;
    logic               sel_tick;
    rcd_state_e         st;
    logic [RATIO_W-1:0] act_ratio;

    rcd_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .word0(word0), .word1(word1)
    );

    rcd_decode #(
        .DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .SEL_LSB(SEL_LSB),
        .RAT_W(RAT_W), .RAT_LSB(RAT_LSB), .RAT_REG(RAT_REG),
        .RAT_STEP(RAT_STEP), .RAT_ZERO(RAT_ZERO), .RATIO_W(RATIO_W),
        .SW(SW), .RW(RW)
    ) u_dec (
        .word0(word0), .word1(word1), .src_tick(src_tick),
        .sel_code(rd_src), .sel_ok(rd_src_ok), .sel_tick(sel_tick),
        .rat_raw(rd_rat_raw), .ratio(rd_ratio)
    );

    rcd_fsm #(.RATIO_W(RATIO_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sel_ok(rd_src_ok), .sel_tick(sel_tick),
        .new_ratio(rd_ratio), .div_en(div_en), .div_clk(div_clk),
        .st(st), .act_ratio(act_ratio)
    );

endmodule

// File: rtl/ratio_clk_div_chk.sv
module ratio_clk_div_chk
    import rcd_pkg::*;
#(
    parameter int NUM_SRC = 3,
    parameter int SW      = 2,
    parameter int RATIO_W = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] src_tick,
    input logic               div_en,
    input logic               div_clk,
    input logic [SW-1:0]      rd_src,
    input logic               rd_src_ok,
    input logic [RATIO_W-1:0] rd_ratio,
    input rcd_state_e         st,
    input logic [RATIO_W-1:0] act_ratio
);

    logic cur_tick;
    always_comb begin
        cur_tick = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (int'(rd_src) == i) cur_tick = src_tick[i];
        end
    end

    // R5
    silent_when_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_src_ok |-> (!div_en && !div_clk));

    // R7
    pulse_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_en |-> cur_tick);

    // R7
    high_after_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HIGH && $past(st) != ST_HIGH) |-> ($past(div_en) || $past(st) == ST_STOP));

    // R9
    ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == ST_HIGH || ($past(st) == ST_LOW && !$past(div_en))) |-> $stable(act_ratio));

    // R3
    ratio_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ratio != '0);

    // R8
    low_at_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_en && st != ST_PASS) |-> !div_clk);

endmodule

bind ratio_clk_div ratio_clk_div_chk #(
    .NUM_SRC(NUM_SRC), .SW(SW), .RATIO_W(RATIO_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .div_en(div_en),
    .div_clk(div_clk), .rd_src(rd_src), .rd_src_ok(rd_src_ok),
    .rd_ratio(rd_ratio), .st(st), .act_ratio(act_ratio)
);

// File: tb/ratio_clk_div_test.sv
module ratio_clk_div_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  src_tick = 3'b000;
    logic        wr_addr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_en_a = 1'b0, wr_en_b = 1'b0;

    logic a_en, a_clk, a_ok, b_en, b_clk, b_ok, c_en, c_clk, c_ok;
    logic [1:0] a_src;
    logic [0:0] b_src, c_src, c_raw;
    logic [4:0] a_raw;
    logic [2:0] b_raw;
    logic [6:0] a_ratio;
    logic [3:0] b_ratio;
    logic [0:0] c_ratio;

    always #5 clk = ~clk;

    ratio_clk_div uut (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick), .wr_en(wr_en_a),
        .wr_addr(wr_addr), .wr_data(wr_data), .div_en(a_en), .div_clk(a_clk),
        .rd_src(a_src), .rd_src_ok(a_ok), .rd_rat_raw(a_raw), .rd_ratio(a_ratio)
    );

    ratio_clk_div #(.NUM_SRC(2), .SEL_W(1), .RAT_W(3), .RAT_LSB(0), .RAT_REG(0),
                    .RAT_STEP(1), .RAT_ZERO(0)) uut_b (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick[1:0]), .wr_en(wr_en_b),
        .wr_addr(wr_addr), .wr_data(wr_data), .div_en(b_en), .div_clk(b_clk),
        .rd_src(b_src), .rd_src_ok(b_ok), .rd_rat_raw(b_raw), .rd_ratio(b_ratio)
    );

    ratio_clk_div #(.NUM_SRC(1), .SEL_W(0), .RAT_W(0), .RAT_STEP(1), .RAT_ZERO(0)) uut_c (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick[0:0]), .wr_en(1'b0),
        .wr_addr(wr_addr), .wr_data(wr_data), .div_en(c_en), .div_clk(c_clk),
        .rd_src(c_src), .rd_src_ok(c_ok), .rd_rat_raw(c_raw), .rd_ratio(c_ratio)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0, ph = 0;
    bit done = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Source 0 ticks every cycle, source 1 every 2nd, source 2 every 3rd.
    initial forever begin
        @(posedge clk); #1;
        ph = ph + 1;
        src_tick = {ph % 3 == 0, ph % 2 == 0, 1'b1};
    end

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Scoreboard
    typedef struct { int per; int hi; string req; } item_t;
    item_t q[$];
    item_t it;
    int  mon_sel = 0, last = 0, hc = 0;
    bit  armed = 0;
    logic mon_en, mon_clk;
    assign mon_en  = (mon_sel == 0) ? a_en  : (mon_sel == 1) ? b_en  : c_en;
    assign mon_clk = (mon_sel == 0) ? a_clk : (mon_sel == 1) ? b_clk : c_clk;

    always @(negedge clk) begin
        if (armed) begin
            hc = hc + int'(mon_clk);
            if (mon_en) begin
                if (q.size() > 0) begin
                    it = q.pop_front();
                    check({it.req, " period"}, cyc - last, it.per);
                    check({it.req, " high"}, hc, it.hi);
                end
                last = cyc;
                hc = 0;
            end
        end
    end

    task automatic wr(bit to_b, bit addr, logic [31:0] data);
        @(posedge clk); #1;
        wr_addr = addr; wr_data = data;
        if (to_b) wr_en_b = 1'b1; else wr_en_a = 1'b1;
        @(posedge clk); #1;
        wr_en_a = 1'b0; wr_en_b = 1'b0;
    endtask

    task automatic sync_arm();
        armed = 0;
        do @(negedge clk); while (!mon_en);
        #1;
        last = cyc; hc = 0; armed = 1;
    endtask

    task automatic push(int r, int tp, string req);
        item_t e;
        e.per = r * tp;
        e.hi  = (r == 1) ? 1 : (r / 2) * tp;
        e.req = req;
        q.push_back(e);
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
        armed = 0;
    endtask

    task automatic expect_periods(int r, int tp, int n, string req);
        sync_arm();
        for (int i = 0; i < n; i++) push(r, tp, req);
        drain();
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            summary();
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 a_en", a_en, 0);
        check("R1 a_clk", a_clk, 0);
        check("R1 a_ratio", a_ratio, 20);
        check("R1 a_src_ok", a_ok, 1);
        check("R1 a_src", a_src, 0);
        check("R1 b_ratio", b_ratio, 1);
        @(posedge clk); #1 rst_n = 1'b1;

        // R4: zero code gives 20
        expect_periods(20, 1, 2, "R4");

        // R3: field 3 -> 8
        wr(0, 1, 32'd3 << 24);
        @(negedge clk);
        check("R3 raw", a_raw, 3);
        check("R3 ratio", a_ratio, 8);
        expect_periods(8, 1, 2, "R7");

        // R9: change 8 -> 12 mid-period
        sync_arm();
        push(8, 1, "R9 old");
        push(12, 1, "R9 new");
        repeat (2) @(posedge clk);
        wr(0, 1, 32'd5 << 24);
        drain();

        // R3: field 31 -> 64
        wr(0, 1, 32'd31 << 24);
        @(negedge clk);
        check("R3 max", a_ratio, 64);
        expect_periods(64, 1, 1, "R3");

        // R2: low bits of word 0 do not touch the ratio of this instance
        wr(0, 0, (32'd2 << 8) | 32'd5);
        @(negedge clk);
        check("R2 ratio kept", a_ratio, 64);
        check("R5 src", a_src, 2);
        wr(0, 1, 32'd0);
        expect_periods(20, 3, 2, "R5 src2");

        wr(0, 0, 32'd1 << 8);
        expect_periods(20, 2, 1, "R5 src1");

        // R5: out-of-range code
        wr(0, 0, 32'd3 << 8);
        begin
            int pulses = 0, highs = 0;
            @(negedge clk);
            check("R5 ok", a_ok, 0);
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                pulses += int'(a_en);
                highs  += int'(a_clk);
            end
            check("R5 pulses", pulses, 0);
            check("R5 highs", highs, 0);
        end
        wr(0, 0, 32'd0);

        // Second instance: odd ratio, ratio 1, shared word
        mon_sel = 1;
        wr(1, 0, 32'd4);
        @(negedge clk);
        check("R3 b ratio", b_ratio, 5);
        expect_periods(5, 1, 2, "R8 odd");
        wr(1, 0, 32'd7);
        @(negedge clk);
        check("R3 b max", b_ratio, 8);
        wr(1, 0, 32'd0);
        @(negedge clk);
        check("R3 b one", b_ratio, 1);
        expect_periods(1, 1, 3, "R8 pass");
        wr(1, 0, (32'd1 << 8) | 32'd2);
        expect_periods(3, 2, 2, "R5 b src1");
        wr(1, 1, 32'd7);
        @(negedge clk);
        check("R2 b word1", b_ratio, 3);

        // R6: fixed instance
        mon_sel = 2;
        check("R6 ratio", c_ratio, 1);
        expect_periods(1, 1, 3, "R6");

        done = 1;
        summary();
    end

endmodule